// File: doc/BRIEF.md
# Fuse Array Word-Read Sequencer

This block copies a contiguous range of a one-time-programmable fuse array into a byte buffer. A request gives a start address, a byte count and a one-cycle start pulse. The sequencer checks alignment, powers the fuse macro up in a fixed order, reads one 32-bit word per address, and writes each word to the buffer as four bytes. It then powers the macro down in the mirror order and reports the result.

Each word read is a single-cycle strobe that carries the address and clears the macro's ready flag. The sequencer then samples ready once every poll interval. It gives up with a busy error when a set number of polls pass without ready. The settle gap between the two power switches and the poll interval are cycle-count parameters. A strap input, sampled with the request, selects a silicon variant that has no power switches or isolation: for that variant only the write-mask and burst controls are driven. The poll interval must be at least two cycles, so that the macro has cleared ready before the first sample.

Top module: `fuse_rd_seq`

## Requirements
- R1: If start_addr[1:0] or byte_cnt[1:0] is nonzero, the request is rejected. On the next cycle err pulses with err_code = 1. No control output changes and no fuse_rd is issued.
- R2: An aligned request with byte_cnt = 0 pulses done on the next cycle with err_code = 0. No control output changes and no fuse_rd is issued.
- R3: Power-up order, each step on its own cycle: wmask_dis rises, then pwr_sw_small rises, then pwr_sw_big rises, then core_iso falls, then burst_en rises, and only then does the first fuse_rd occur.
- R4: On power-up, pwr_sw_big rises at least SETTLE_CYC cycles after pwr_sw_small. On power-down, pwr_sw_small falls at least SETTLE_CYC cycles after pwr_sw_big.
- R5: Power-down order: core_iso rises, then pwr_sw_big falls, then pwr_sw_small falls, then wmask_dis and burst_en fall together, and then done or err pulses.
- R6: When skip_pwr_seq is 1 at start, pwr_sw_small, pwr_sw_big and core_iso never change during the request. wmask_dis and burst_en still rise before the reads and fall after them.
- R7: Each word is read with a one-cycle fuse_rd pulse that presents fuse_addr. Words are read at start_addr, start_addr+4, and so on, one fuse_rd per word. fuse_rd occurs only while burst_en and wmask_dis are 1.
- R8: fuse_rdy is sampled every POLL_CYC cycles after a fuse_rd. If POLL_MAX samples see it low, the request aborts. core_iso rises exactly POLL_CYC*POLL_MAX+1 cycles after the strobe, and the request ends with err and err_code = 2, without writing any byte of that word.
- R9: Each word is written to the buffer in little-endian order, byte 0 being fuse_data[7:0]. Buffer byte address 4k+j (j = 0..3) holds byte j of the k-th word read.
- R10: When done or err pulses at the end of a powered request, all controls are idle: wmask_dis, pwr_sw_small, pwr_sw_big and burst_en are 0, and core_iso is 1.
- R11: done and err never pulse together. A completed read pulses done with err_code = 0, and busy is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken while idle |
| start_addr | input | ADDR_W | First fuse byte address |
| byte_cnt | input | ADDR_W+1 | Number of bytes to read |
| skip_pwr_seq | input | 1 | Variant strap: skip power switches and isolation |
| wmask_dis | output | 1 | Write-mask disable control |
| pwr_sw_small | output | 1 | Small power switch enable |
| pwr_sw_big | output | 1 | Big power switch enable |
| core_iso | output | 1 | Core isolation (1 = isolated, idle value) |
| burst_en | output | 1 | Burst mode enable |
| fuse_rd | output | 1 | Word read strobe; clears ready in the macro |
| fuse_addr | output | ADDR_W | Word address, valid with fuse_rd |
| fuse_rdy | input | 1 | Macro ready flag |
| fuse_data | input | 32 | Word returned by the macro |
| buf_we | output | 1 | Buffer byte write enable |
| buf_addr | output | ADDR_W+1 | Buffer byte offset from the start of the request |
| buf_wdata | output | 8 | Buffer write byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | Successful completion pulse |
| err | output | 1 | Error completion pulse |
| err_code | output | 2 | 0 none, 1 alignment, 2 ready timeout |

## Verification
An alignment reject and a zero-length request are due one cycle after start. The bench drives start just after a falling edge and reads done, err and err_code at the following falling edge. A bench monitor timestamps every control edge, strobe and byte write at the falling edges. The order and gap checks compare those timestamps: strictly increasing for each step, a difference of at least SETTLE_CYC for the switch pair, and exactly POLL_CYC*POLL_MAX+1 cycles from the last strobe to the rise of core_iso on a timeout. Buffer contents are compared with a word function that the bench computes from each address.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_PU_WM,
    S_PU_SW_S,
    S_PU_SETTLE,
    S_PU_SW_B,
    S_PU_ISO,
    S_PU_BURST,
    S_RD_ISSUE,
    S_RD_POLL,
    S_RD_STORE,
    S_PD_ISO,
    S_PD_SW_B,
    S_PD_SETTLE,
    S_PD_SW_S,
    S_PD_CLR,
    S_END
  } seq_state_t;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_ALIGN = 2'd1,
    ERR_BUSY  = 2'd2
  } err_code_t;

endpackage

// File: rtl/fuse_rd_delay.sv
// Loadable countdown; expired is high while the count is zero.
module fuse_rd_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= len;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/fuse_rd_byte_ser.sv
// Splits a word into bytes, least significant first, one per cycle.
module fuse_rd_byte_ser #(
  parameter int WORD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic [8*WORD_BYTES-1:0]       word,
  output logic                          we,
  output logic [7:0]                    byte_out,
  output logic [$clog2(WORD_BYTES)-1:0] idx,
  output logic                          last
);

  localparam int IDX_W = $clog2(WORD_BYTES);
  localparam int WW    = 8 * WORD_BYTES;

  logic [WW-1:0]    sh_q;
  logic [IDX_W-1:0] idx_q;
  logic             act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      sh_q  <= word;
      idx_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      sh_q  <= sh_q >> 8;
      idx_q <= idx_q + 1'b1;
      if (idx_q == IDX_W'(WORD_BYTES - 1)) act_q <= 1'b0;
    end
  end

  assign we       = act_q;
  assign byte_out = sh_q[7:0];
  assign idx      = idx_q;
  assign last     = act_q && (idx_q == IDX_W'(WORD_BYTES - 1));

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SETTLE_CYC = 125000,
  parameter int POLL_CYC   = 125,
  parameter int POLL_MAX   = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W:0]   byte_cnt,
  input  logic              skip_pwr_seq,
  output logic              wmask_dis,
  output logic              pwr_sw_small,
  output logic              pwr_sw_big,
  output logic              core_iso,
  output logic              burst_en,
  output logic              fuse_rd,
  output logic [ADDR_W-1:0] fuse_addr,
  input  logic              fuse_rdy,
  input  logic [31:0]       fuse_data,
  output logic              buf_we,
  output logic [ADDR_W:0]   buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code
);

  localparam int CNT_W   = ADDR_W + 1;
  localparam int DLY_MAX = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam int PW      = $clog2(POLL_MAX + 1);

  seq_state_t        state;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q, off_q;
  logic [PW-1:0]     poll_q;
  logic              byp_q, timeout_q;

  logic              dly_load, dly_exp;
  logic [DLY_W-1:0]  dly_len;
  logic              ser_load, ser_we, ser_last;
  logic [7:0]        ser_byte;
  logic [1:0]        ser_idx;
  logic              misaligned, poll_last;

  assign misaligned = (start_addr[1:0] != 2'b00) || (byte_cnt[1:0] != 2'b00);
  assign poll_last  = (poll_q == PW'(POLL_MAX - 1));
  assign ser_load   = (state == S_RD_POLL) && dly_exp && fuse_rdy;

  always_comb begin
    dly_load = 1'b0;
    dly_len  = '0;
    case (state)
      S_PU_SW_S, S_PD_SW_B: begin
        dly_load = 1'b1;
        dly_len  = DLY_W'(SETTLE_CYC - 1);
      end
      S_RD_ISSUE: begin
        dly_load = 1'b1;
        dly_len  = DLY_W'(POLL_CYC - 1);
      end
      S_RD_POLL: begin
        dly_load = dly_exp && !fuse_rdy;
        dly_len  = DLY_W'(POLL_CYC - 1);
      end
      default: ;
    endcase
  end

  fuse_rd_delay #(.W(DLY_W)) dly_i (
    .clk(clk), .rst(rst), .load(dly_load), .len(dly_len), .expired(dly_exp)
  );

  fuse_rd_byte_ser #(.WORD_BYTES(4)) ser_i (
    .clk(clk), .rst(rst), .load(ser_load), .word(fuse_data),
    .we(ser_we), .byte_out(ser_byte), .idx(ser_idx), .last(ser_last)
  );

  assign buf_we    = ser_we;
  assign buf_wdata = ser_byte;
  assign buf_addr  = off_q + CNT_W'(ser_idx);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      addr_q       <= '0;
      rem_q        <= '0;
      off_q        <= '0;
      poll_q       <= '0;
      byp_q        <= 1'b0;
      timeout_q    <= 1'b0;
      wmask_dis    <= 1'b0;
      pwr_sw_small <= 1'b0;
      pwr_sw_big   <= 1'b0;
      core_iso     <= 1'b1;
      burst_en     <= 1'b0;
      fuse_rd      <= 1'b0;
      fuse_addr    <= '0;
      done         <= 1'b0;
      err          <= 1'b0;
      err_code     <= ERR_NONE;
    end else begin
      done    <= 1'b0;
      err     <= 1'b0;
      fuse_rd <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (misaligned) begin
            err      <= 1'b1;
            err_code <= ERR_ALIGN;
          end else if (byte_cnt == '0) begin
            done     <= 1'b1;
            err_code <= ERR_NONE;
          end else begin
            addr_q    <= start_addr;
            rem_q     <= byte_cnt;
            off_q     <= '0;
            byp_q     <= skip_pwr_seq;
            timeout_q <= 1'b0;
            state     <= S_PU_WM;
          end
        end
        S_PU_WM: begin
          wmask_dis <= 1'b1;
          state     <= byp_q ? S_PU_BURST : S_PU_SW_S;
        end
        S_PU_SW_S: begin
          pwr_sw_small <= 1'b1;
          state        <= S_PU_SETTLE;
        end
        S_PU_SETTLE: if (dly_exp) state <= S_PU_SW_B;
        S_PU_SW_B: begin
          pwr_sw_big <= 1'b1;
          state      <= S_PU_ISO;
        end
        S_PU_ISO: begin
          core_iso <= 1'b0;
          state    <= S_PU_BURST;
        end
        S_PU_BURST: begin
          burst_en <= 1'b1;
          state    <= S_RD_ISSUE;
        end
        S_RD_ISSUE: begin
          fuse_addr <= addr_q;
          fuse_rd   <= 1'b1;
          poll_q    <= '0;
          state     <= S_RD_POLL;
        end
        S_RD_POLL: if (dly_exp) begin
          if (fuse_rdy) begin
            state <= S_RD_STORE;
          end else if (poll_last) begin
            timeout_q <= 1'b1;
            state     <= byp_q ? S_PD_CLR : S_PD_ISO;
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        S_RD_STORE: if (ser_last) begin
          addr_q <= addr_q + ADDR_W'(4);
          off_q  <= off_q + CNT_W'(4);
          rem_q  <= rem_q - CNT_W'(4);
          if (rem_q == CNT_W'(4)) state <= byp_q ? S_PD_CLR : S_PD_ISO;
          else                    state <= S_RD_ISSUE;
        end
        S_PD_ISO: begin
          core_iso <= 1'b1;
          state    <= S_PD_SW_B;
        end
        S_PD_SW_B: begin
          pwr_sw_big <= 1'b0;
          state      <= S_PD_SETTLE;
        end
        S_PD_SETTLE: if (dly_exp) state <= S_PD_SW_S;
        S_PD_SW_S: begin
          pwr_sw_small <= 1'b0;
          state        <= S_PD_CLR;
        end
        S_PD_CLR: begin
          wmask_dis <= 1'b0;
          burst_en  <= 1'b0;
          state     <= S_END;
        end
        S_END: begin
          if (timeout_q) begin
            err      <= 1'b1;
            err_code <= ERR_BUSY;
          end else begin
            done     <= 1'b1;
            err_code <= ERR_NONE;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fuse_rd_seq_chk.sv
module fuse_rd_seq_chk #(
  parameter int ADDR_W     = 12,
  parameter int SETTLE_CYC = 125000
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W:0]   byte_cnt,
  input logic              byp_q,
  input logic              wmask_dis,
  input logic              pwr_sw_small,
  input logic              pwr_sw_big,
  input logic              core_iso,
  input logic              burst_en,
  input logic              fuse_rd,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [1:0]        err_code
);

  logic        small_q, big_q;
  logic [31:0] since_small, since_big;

  always_ff @(posedge clk) begin
    if (rst) begin
      small_q     <= 1'b0;
      big_q       <= 1'b0;
      since_small <= '0;
      since_big   <= '0;
    end else begin
      small_q <= pwr_sw_small;
      big_q   <= pwr_sw_big;
      if (pwr_sw_small != small_q) since_small <= 32'd1;
      else if (since_small != '1)  since_small <= since_small + 32'd1;
      if (pwr_sw_big != big_q)     since_big <= 32'd1;
      else if (since_big != '1)    since_big <= since_big + 32'd1;
    end
  end

  assert_align_reject_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (start_addr[1:0] != 2'b00 || byte_cnt[1:0] != 2'b00))
    |=> (err && err_code == 2'd1 && !busy));

  assert_zero_len_done_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && start_addr[1:0] == 2'b00 && byte_cnt == '0)
    |=> (done && !busy));

  assert_big_after_small_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_sw_big) |-> (pwr_sw_small && wmask_dis && core_iso && !burst_en));

  assert_iso_release_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(core_iso) |-> (pwr_sw_big && !burst_en));

  assert_burst_last_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_en) |-> (wmask_dis && (byp_q || !core_iso)));

  assert_settle_up_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_sw_big) |-> (since_small >= 32'(SETTLE_CYC)));

  assert_settle_down_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_sw_small) |-> (since_big >= 32'(SETTLE_CYC)));

  assert_iso_first_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(core_iso) |-> (pwr_sw_big && pwr_sw_small && burst_en));

  assert_small_last_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_sw_small) |-> (!pwr_sw_big && core_iso && wmask_dis));

  assert_bypass_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && byp_q) |-> (!pwr_sw_small && !pwr_sw_big && core_iso));

  assert_read_powered_R7: assert property (@(posedge clk) disable iff (rst)
    fuse_rd |-> (burst_en && wmask_dis));

  assert_idle_at_end_R10: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> (!wmask_dis && !pwr_sw_small && !pwr_sw_big && core_iso && !burst_en));

  assert_single_end_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, err}));

endmodule

bind fuse_rd_seq fuse_rd_seq_chk #(
  .ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)
) chk_i (
  .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
  .byte_cnt(byte_cnt), .byp_q(byp_q), .wmask_dis(wmask_dis),
  .pwr_sw_small(pwr_sw_small), .pwr_sw_big(pwr_sw_big), .core_iso(core_iso),
  .burst_en(burst_en), .fuse_rd(fuse_rd), .busy(busy), .done(done),
  .err(err), .err_code(err_code)
);

// File: tb/fuse_rd_seq_tb_top.sv
module fuse_rd_seq_tb_top;

  localparam int AW     = 12;
  localparam int SETTLE = 20;
  localparam int POLL   = 3;
  localparam int PMAX   = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW:0]   byte_cnt = '0;
  logic          skip_pwr_seq = 1'b0;
  logic          wmask_dis, pwr_sw_small, pwr_sw_big, core_iso, burst_en;
  logic          fuse_rd, fuse_rdy;
  logic [AW-1:0] fuse_addr;
  logic [31:0]   fuse_data;
  logic          buf_we, busy, done, err;
  logic [AW:0]   buf_addr;
  logic [7:0]    buf_wdata;
  logic [1:0]    err_code;

  always #4 clk = ~clk;

  fuse_rd_seq #(
    .ADDR_W(AW), .SETTLE_CYC(SETTLE), .POLL_CYC(POLL), .POLL_MAX(PMAX)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .byte_cnt(byte_cnt), .skip_pwr_seq(skip_pwr_seq),
    .wmask_dis(wmask_dis), .pwr_sw_small(pwr_sw_small), .pwr_sw_big(pwr_sw_big),
    .core_iso(core_iso), .burst_en(burst_en), .fuse_rd(fuse_rd),
    .fuse_addr(fuse_addr), .fuse_rdy(fuse_rdy), .fuse_data(fuse_data),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .busy(busy), .done(done), .err(err), .err_code(err_code)
  );

  function automatic logic [31:0] fuse_word(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h33, ~a[7:0], a[7:0] ^ 8'hC3};
  endfunction

  // Behavioural fuse macro: ready clears on a strobe, returns after stub_lat cycles.
  int            stub_lat = 2;
  bit            stub_never = 1'b0;
  int            stub_cnt;
  logic [AW-1:0] stub_a;

  always @(posedge clk) begin
    if (rst) begin
      fuse_rdy  <= 1'b1;
      fuse_data <= 32'h0;
      stub_cnt  <= 0;
      stub_a    <= '0;
    end else if (fuse_rd) begin
      fuse_rdy <= 1'b0;
      stub_cnt <= stub_lat;
      stub_a   <= fuse_addr;
    end else if (!fuse_rdy && !stub_never) begin
      if (stub_cnt <= 1) begin
        fuse_rdy  <= 1'b1;
        fuse_data <= fuse_word(stub_a);
      end else begin
        stub_cnt <= stub_cnt - 1;
      end
    end
  end

  // Monitor at the falling edge: timestamps of every event.
  int            cyc = 0;
  bit            log_clr = 1'b0;
  logic          p_wm, p_sm, p_bg, p_iso, p_bu;
  int            t_wm_r, t_wm_f, t_sm_r, t_sm_f, t_bg_r, t_bg_f, t_iso_r, t_iso_f;
  int            t_bu_r, t_bu_f, t_end, t_rd_last, n_rd, n_we, n_ctl;
  logic [AW-1:0] rd_log [0:15];
  logic [7:0]    mem [0:63];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (log_clr) begin
      t_wm_r = -1; t_wm_f = -1; t_sm_r = -1; t_sm_f = -1; t_bg_r = -1; t_bg_f = -1;
      t_iso_r = -1; t_iso_f = -1; t_bu_r = -1; t_bu_f = -1; t_end = -1; t_rd_last = -1;
      n_rd = 0; n_we = 0; n_ctl = 0;
      for (int i = 0; i < 64; i++) mem[i] = 8'hEE;
    end else begin
      if (wmask_dis != p_wm) begin n_ctl++; if (wmask_dis) t_wm_r = cyc; else t_wm_f = cyc; end
      if (pwr_sw_small != p_sm) begin n_ctl++; if (pwr_sw_small) t_sm_r = cyc; else t_sm_f = cyc; end
      if (pwr_sw_big != p_bg) begin n_ctl++; if (pwr_sw_big) t_bg_r = cyc; else t_bg_f = cyc; end
      if (core_iso != p_iso) begin n_ctl++; if (core_iso) t_iso_r = cyc; else t_iso_f = cyc; end
      if (burst_en != p_bu) begin n_ctl++; if (burst_en) t_bu_r = cyc; else t_bu_f = cyc; end
      if (fuse_rd) begin
        if (n_rd < 16) rd_log[n_rd] = fuse_addr;
        n_rd++;
        t_rd_last = cyc;
      end
      if (buf_we) begin
        if (buf_addr < 64) mem[buf_addr[5:0]] = buf_wdata;
        n_we++;
      end
      if (done || err) t_end = cyc;
    end
    p_wm = wmask_dis; p_sm = pwr_sw_small; p_bg = pwr_sw_big; p_iso = core_iso; p_bu = burst_en;
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic clear_log();
    log_clr = 1'b1;
    tick();
    log_clr = 1'b0;
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic [AW:0] n, input bit byp);
    start_addr   = a;
    byte_cnt     = n;
    skip_pwr_seq = byp;
    start        = 1'b1;
    tick();
    start        = 1'b0;
    skip_pwr_seq = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 3000 && !(done || err); k++) tick();
  endtask

  task automatic idle_ctl_ok(input string req);
    check(!wmask_dis && !pwr_sw_small && !pwr_sw_big && core_iso && !burst_en,
          req, "controls idle",
          {wmask_dis, pwr_sw_small, pwr_sw_big, core_iso, burst_en}, 5'b00010);
  endtask

  task automatic check_data(input logic [AW-1:0] a, input int n, input string req);
    for (int k = 0; k < n / 4; k++) begin
      logic [31:0] w;
      w = fuse_word(a + AW'(4 * k));
      for (int j = 0; j < 4; j++)
        check(mem[4 * k + j] == w[8 * j +: 8], req, "buffer byte",
              mem[4 * k + j], w[8 * j +: 8]);
    end
    check(n_we == n, req, "byte writes", n_we, n);
  endtask

  task automatic t_reset();
    idle_ctl_ok("R10");
    check(!busy && !done && !err, "R11", "reset flags", {busy, done, err}, 0);
  endtask

  task automatic t_align(input logic [AW-1:0] a, input logic [AW:0] n);
    clear_log();
    issue(a, n, 1'b0);
    check(err == 1'b1 && !done, "R1", "align err pulse", {err, done}, 2'b10);
    check(err_code == 2'd1, "R1", "align code", err_code, 1);
    repeat (4) tick();
    check(n_ctl == 0 && n_rd == 0, "R1", "no activity", n_ctl + n_rd, 0);
    check(!busy, "R1", "not busy", busy, 0);
  endtask

  task automatic t_zero();
    clear_log();
    issue(12'h020, '0, 1'b0);
    check(done == 1'b1 && !err, "R2", "zero done", {done, err}, 2'b10);
    check(err_code == 2'd0, "R2", "zero code", err_code, 0);
    repeat (3) tick();
    check(n_ctl == 0 && n_rd == 0, "R2", "no activity", n_ctl + n_rd, 0);
  endtask

  task automatic t_normal();
    clear_log();
    stub_lat = 2;
    issue(12'h010, 13'd12, 1'b0);
    wait_end();
    check(done && !err && err_code == 2'd0, "R11", "done ok", {done, err, err_code}, 4'b1000);
    idle_ctl_ok("R10");
    tick();
    check(t_wm_r > 0 && t_wm_r < t_sm_r, "R3", "wmask before small", t_wm_r, t_sm_r);
    check(t_bg_r - t_sm_r >= SETTLE, "R4", "up settle gap", t_bg_r - t_sm_r, SETTLE);
    check(t_bg_r < t_iso_f && t_iso_f < t_bu_r, "R3", "big, iso, burst order", t_iso_f, t_bu_r);
    check(rd_log[0] == 12'h010 && n_rd == 3, "R7", "first read and count", n_rd, 3);
    check(rd_log[1] == 12'h014 && rd_log[2] == 12'h018, "R7", "read address step",
          rd_log[2], 12'h018);
    check(t_iso_r > t_rd_last && t_iso_r < t_bg_f, "R5", "iso before big off", t_iso_r, t_bg_f);
    check(t_sm_f - t_bg_f >= SETTLE, "R4", "down settle gap", t_sm_f - t_bg_f, SETTLE);
    check(t_sm_f < t_wm_f && t_wm_f == t_bu_f && t_wm_f < t_end, "R5", "final clears",
          t_wm_f, t_bu_f);
    check_data(12'h010, 12, "R9");
    check(!busy, "R11", "idle after done", busy, 0);
  endtask

  task automatic t_bypass();
    clear_log();
    stub_lat = 7;
    issue(12'h040, 13'd8, 1'b1);
    wait_end();
    check(done && err_code == 2'd0, "R6", "bypass done", done, 1);
    tick();
    check(t_sm_r == -1 && t_bg_r == -1 && t_iso_f == -1 && t_iso_r == -1, "R6",
          "switches untouched", t_sm_r + t_bg_r + t_iso_f + t_iso_r, -4);
    check(t_wm_r > 0 && t_bu_r > t_wm_r && t_bu_f > t_rd_last && t_wm_f > t_rd_last,
          "R6", "wmask and burst toggled", t_bu_r, t_wm_r);
    check(n_rd == 2 && rd_log[1] == 12'h044, "R7", "bypass reads", n_rd, 2);
    check_data(12'h040, 8, "R9");
  endtask

  task automatic t_timeout();
    clear_log();
    stub_never = 1'b1;
    issue(12'h020, 13'd8, 1'b0);
    wait_end();
    check(err && !done && err_code == 2'd2, "R8", "busy error", {err, done, err_code}, 4'b1010);
    idle_ctl_ok("R10");
    tick();
    check(n_rd == 1, "R8", "single strobe", n_rd, 1);
    check(t_iso_r - t_rd_last == POLL * PMAX + 1, "R8", "abort delay",
          t_iso_r - t_rd_last, POLL * PMAX + 1);
    check(n_we == 0, "R8", "no bytes written", n_we, 0);
    check(t_sm_f - t_bg_f >= SETTLE && t_bg_f > t_iso_r, "R5", "abort power-down order",
          t_sm_f - t_bg_f, SETTLE);
    stub_never = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_align(12'h012, 13'd8);
    t_align(12'h010, 13'd6);
    t_zero();
    t_normal();
    t_bypass();
    t_timeout();
    t_normal();
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
    $finish;
  end

endmodule